// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns audio samples into a serial bit stream with matching word-select timing. Software or a DMA engine writes one word at a time into a single holding register. At the start of every slot the block takes the next sample, left-aligns it in the slot and shifts it out MSB first, one bit per bit-clock enable pulse. Clock generation sits outside the block. A clock generator supplies `bclk_en`, a one-cycle pulse at each falling bit-clock edge, and `frame_start`, which is sampled together with `bclk_en` and forces the next bit to be bit 0 of slot 0.

Four framings are supported: two-channel I2S, two-channel left-justified, and delayed or undelayed multi-slot TDM with up to eight slots. A 3-bit length code sets the sample size and slot width. It includes packed modes in which one holding word carries two samples. Further controls give mono duplication of the left channel and a choice of fill value when the holding register is empty at a slot start. A starved slot raises a sticky summary flag and a sticky per-slot flag. Separate strobes start and stop the transmitter.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset, `tx_enabled`, `sdo`, `ws`, `ur_any` and `ur_slot` are 0 and `tx_ready` is 1. A `wr_en` pulse makes `tx_ready` 0 from the next cycle. Once an enabled slot start takes the word, `tx_ready` returns to 1.
- R2: An `en_set` pulse sets `tx_enabled` on the next cycle and an `en_clr` pulse clears it. When both pulse in the same cycle, the transmitter ends up disabled.
- R3: While the transmitter is disabled, `sdo` is held at 0 from the second cycle on, the holding register is not consumed (`tx_ready` stays 0 after a write) and no underrun is recorded.
- R4: `len_code` selects the sample length and slot width. Codes 0/1/2/3 give 32/24/20/18-bit samples. Codes 4 and 5 give 16-bit samples in 16-bit slots, and codes 6 and 7 give 8-bit samples in 8-bit slots. For codes 1 to 3, `slot24` = 1 gives 24-bit slots and 0 gives 32-bit slots. Code 0 always uses 32-bit slots.
- R5: Each sample is sent MSB first, starting at the slot's first bit. Slot bits past the sample length are 0.
- R6: `fmt` 0 (I2S) and 2 (TDM) delay the MSB by one bit clock after the slot boundary. `fmt` 1 (left-justified) and 3 (TDM left-justified) have no delay.
- R7: For `fmt` 0 and 1 a frame has two slots, and `ws` is 0 during slot 0 and 1 during slot 1. For `fmt` 2 and 3 a frame has `tdm_last`+1 slots, and `ws` is 1 only during the first bit of the frame.
- R8: `frame_start` together with `bclk_en` restarts the frame at bit 0 of slot 0, which takes a fresh sample.
- R9: `sdo` and `ws` change only in the cycle after a `bclk_en` pulse, or when the transmitter is disabled.
- R10: With `mono` = 1 in `fmt` 0 or 1, slot 1 repeats the slot 0 sample and consumes no word.
- R11: Codes 5 and 7 are packed. A word taken at an even slot supplies its low half (bits 15:0 for code 5, bits 7:0 for code 7) to that slot and its next half (bits 31:16 or 15:8) to the following odd slot.
- R12: When a slot needs a new word and the holding register is empty, the slot carries 0 if `fill_prev` = 0, or the sample sent in the previous slot if `fill_prev` = 1.
- R13: A starved slot sets `ur_any` and bit `ur_slot[slot index]`. Both stay set until a `ur_clr` pulse clears them on the next cycle.
- R14: Samples are right-aligned in the holding word, and word bits above the sample length are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle pulse at each falling bit-clock edge |
| frame_start | input | 1 | Frame restart, sampled with `bclk_en` |
| en_set | input | 1 | Transmitter start strobe |
| en_clr | input | 1 | Transmitter stop strobe |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 32 | Holding register write data |
| fmt | input | 2 | Framing code |
| len_code | input | 3 | Sample length code |
| slot24 | input | 1 | 24-bit slot select for 18/20/24-bit samples |
| mono | input | 1 | Duplicate left sample into right slot |
| fill_prev | input | 1 | Underrun fill: 0 zero, 1 previous sample |
| tdm_last | input | 3 | Number of TDM slots minus one |
| ur_clr | input | 1 | Clears the underrun flags |
| sdo | output | 1 | Serial data |
| ws | output | 1 | Word select / frame sync |
| tx_ready | output | 1 | Holding register is empty |
| tx_enabled | output | 1 | Transmitter enabled status |
| ur_any | output | 1 | Sticky underrun summary |
| ur_slot | output | 8 | Sticky per-slot underrun flags |

## Verification
The assertions check the strobe, status and flag rules on every cycle. These cover the enable and disable outcome, a write clearing ready, the absence of consumption and the silent line while disabled, flag stickiness and clearing, agreement between the summary and per-slot flags, and `sdo` moving only after a bit-clock pulse. The bit streams are checked only in the bench scenarios. These cover the per-format delay, slot widths and zero padding, word-select shape, packed-half order, mono duplication, the two fill choices and the frame restart. In each scenario, captured `sdo` and `ws` are compared bit by bit against a stream built from the requirements.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;

    localparam int SMP_W     = 32;
    localparam int MAX_SLOTS = 8;
    localparam int POS_W     = $clog2(SMP_W);
    localparam int LEN_W     = $clog2(SMP_W) + 1;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LJ    = 2'd1,
        FMT_TDM   = 2'd2,
        FMT_TDMLJ = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        LEN32  = 3'd0,
        LEN24  = 3'd1,
        LEN20  = 3'd2,
        LEN18  = 3'd3,
        LEN16  = 3'd4,
        LEN16P = 3'd5,
        LEN8   = 3'd6,
        LEN8P  = 3'd7
    } len_e;

    // where the sample for a slot comes from
    typedef enum logic [2:0] {
        SRC_OFF,
        SRC_MONO,
        SRC_HI,
        SRC_FILL,
        SRC_NEW
    } src_e;

    function automatic logic [LEN_W-1:0] smp_bits(len_e l);
        case (l)
            LEN32:         return LEN_W'(32);
            LEN24:         return LEN_W'(24);
            LEN20:         return LEN_W'(20);
            LEN18:         return LEN_W'(18);
            LEN16, LEN16P: return LEN_W'(16);
            default:       return LEN_W'(8);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] slot_last(len_e l, logic s24);
        case (l)
            LEN32:                return POS_W'(31);
            LEN24, LEN20, LEN18:  return s24 ? POS_W'(23) : POS_W'(31);
            LEN16, LEN16P:        return POS_W'(15);
            default:              return POS_W'(7);
        endcase
    endfunction

    function automatic logic is_packed(len_e l);
        return (l == LEN16P) || (l == LEN8P);
    endfunction

    function automatic logic [SMP_W-1:0] low_mask(len_e l);
        logic [LEN_W-1:0] n;
        n = smp_bits(l);
        if (n == LEN_W'(SMP_W)) return '1;
        return (SMP_W'(1) << n) - SMP_W'(1);
    endfunction

    function automatic logic [SMP_W-1:0] pick_half(logic [SMP_W-1:0] w, len_e l, logic hi);
        case (l)
            LEN16P:  return hi ? SMP_W'(w[31:16]) : SMP_W'(w[15:0]);
            LEN8P:   return hi ? SMP_W'(w[15:8])  : SMP_W'(w[7:0]);
            default: return w;
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] left_align(logic [SMP_W-1:0] s, len_e l);
        return (s & low_mask(l)) << (LEN_W'(SMP_W) - smp_bits(l));
    endfunction

endpackage

// File: rtl/aud_tx_timing.sv
`timescale 1ns/1ps
module aud_tx_timing
    import aud_tx_pkg::*;
#(
    parameter int SLOT_IW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   frame_start,
    input  fmt_e                   fmt,
    input  logic [POS_W-1:0]       last_pos,
    input  logic [SLOT_IW-1:0]     tdm_last,
    output logic                   load,
    output logic [SLOT_IW-1:0]     slot_idx,
    output logic                   ws
);
    logic [POS_W-1:0]   pos_q;
    logic [SLOT_IW-1:0] slot_q;
    logic               restart;
    logic [POS_W-1:0]   eff_pos;
    logic [SLOT_IW-1:0] frame_last;
    logic               is_tdm;

    assign is_tdm     = fmt[1];
    assign restart    = tick & frame_start;
    assign eff_pos    = restart ? '0 : pos_q;
    assign slot_idx   = restart ? '0 : slot_q;
    assign frame_last = is_tdm ? tdm_last : SLOT_IW'(1);
    assign load       = tick & (eff_pos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            slot_q <= '0;
            ws     <= 1'b0;
        end else if (tick) begin
            if (eff_pos >= last_pos) begin
                pos_q  <= '0;
                slot_q <= (slot_idx >= frame_last) ? '0 : slot_idx + SLOT_IW'(1);
            end else begin
                pos_q  <= eff_pos + POS_W'(1);
                slot_q <= slot_idx;
            end
            ws <= is_tdm ? ((slot_idx == '0) && (eff_pos == '0)) : slot_idx[0];
        end
    end
endmodule

// File: rtl/aud_tx_feed.sv
`timescale 1ns/1ps
module aud_tx_feed
    import aud_tx_pkg::*;
#(
    parameter int SLOTS   = MAX_SLOTS,
    parameter int SLOT_IW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 load,
    input  logic [SLOT_IW-1:0]   slot_idx,
    input  len_e                 len,
    input  logic                 mono_ok,
    input  logic                 fill_prev,
    input  logic                 wr_en,
    input  logic [SMP_W-1:0]     wr_data,
    input  logic                 ur_clr,
    output logic [SMP_W-1:0]     word,
    output logic                 tx_ready,
    output logic                 ur_any,
    output logic [SLOTS-1:0]     ur_slot
);
    logic [SMP_W-1:0] hold_q, last_q, pend_q;
    logic             full_q, pend_ur_q;
    logic             packed_m, mono_rep, hi_slot, need_new, starve, ur_now, take;
    logic [SMP_W-1:0] fill, smp;
    src_e             src;
    logic [SLOTS-1:0] hit;

    assign packed_m = is_packed(len);
    assign mono_rep = mono_ok & slot_idx[0];
    assign hi_slot  = packed_m & slot_idx[0] & ~mono_rep;
    assign need_new = ~mono_rep & ~hi_slot;
    assign starve   = need_new & ~full_q;
    assign fill     = fill_prev ? last_q : '0;
    assign take     = en & load;

    always_comb begin
        if (!en)           src = SRC_OFF;
        else if (mono_rep) src = SRC_MONO;
        else if (hi_slot)  src = SRC_HI;
        else if (starve)   src = SRC_FILL;
        else               src = SRC_NEW;
    end

    always_comb begin
        case (src)
            SRC_MONO: smp = last_q;
            SRC_HI:   smp = pend_q;
            SRC_FILL: smp = fill;
            SRC_NEW:  smp = pick_half(hold_q, len, 1'b0) & low_mask(len);
            default:  smp = '0;
        endcase
    end

    assign word     = left_align(smp, len);
    assign tx_ready = ~full_q;
    assign ur_now   = take & (starve | (hi_slot & pend_ur_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            full_q    <= 1'b0;
            last_q    <= '0;
            pend_q    <= '0;
            pend_ur_q <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data;
                full_q <= 1'b1;
            end else if (take && need_new) begin
                full_q <= 1'b0;
            end
            if (take) begin
                last_q <= smp;
                if (need_new) begin
                    pend_q    <= full_q ? pick_half(hold_q, len, 1'b1) : fill;
                    pend_ur_q <= ~full_q;
                end
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = ur_now && (slot_idx == SLOT_IW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || ur_clr) begin
            ur_any  <= 1'b0;
            ur_slot <= '0;
        end else begin
            ur_any  <= ur_any | ur_now;
            ur_slot <= ur_slot | hit;
        end
    end
endmodule

// File: rtl/aud_tx_shift.sv
`timescale 1ns/1ps
module aud_tx_shift
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [SMP_W-1:0] word,
    input  logic             delay,
    output logic             sdo
);
    logic [SMP_W-1:0] sreg_q, nxt;
    logic             early_q, late_q;

    assign nxt = load ? word : {sreg_q[SMP_W-2:0], 1'b0};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sreg_q  <= '0;
            early_q <= 1'b0;
            late_q  <= 1'b0;
        end else if (tick) begin
            sreg_q  <= nxt;
            early_q <= nxt[SMP_W-1];
            late_q  <= early_q;
        end
    end

    assign sdo = delay ? late_q : early_q;
endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int SLOTS = MAX_SLOTS,
    localparam int SLOT_IW = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_en,
    input  logic                 frame_start,
    input  logic                 en_set,
    input  logic                 en_clr,
    input  logic                 wr_en,
    input  logic [SMP_W-1:0]     wr_data,
    input  logic [1:0]           fmt,
    input  logic [2:0]           len_code,
    input  logic                 slot24,
    input  logic                 mono,
    input  logic                 fill_prev,
    input  logic [SLOT_IW-1:0]   tdm_last,
    input  logic                 ur_clr,
    output logic                 sdo,
    output logic                 ws,
    output logic                 tx_ready,
    output logic                 tx_enabled,
    output logic                 ur_any,
    output logic [SLOTS-1:0]     ur_slot
);
    fmt_e               fmt_s;
    len_e               len_s;
    logic               load;
    logic [SLOT_IW-1:0] slot_idx;
    logic [SMP_W-1:0]   word;

    assign fmt_s = fmt_e'(fmt);
    assign len_s = len_e'(len_code);

    always_ff @(posedge clk) begin
        if (rst)         tx_enabled <= 1'b0;
        else if (en_clr) tx_enabled <= 1'b0;
        else if (en_set) tx_enabled <= 1'b1;
    end

    aud_tx_timing #(.SLOT_IW(SLOT_IW)) u_timing (
        .clk         (clk),
        .rst         (rst),
        .tick        (bclk_en),
        .frame_start (frame_start),
        .fmt         (fmt_s),
        .last_pos    (slot_last(len_s, slot24)),
        .tdm_last    (tdm_last),
        .load        (load),
        .slot_idx    (slot_idx),
        .ws          (ws)
    );

    aud_tx_feed #(.SLOTS(SLOTS), .SLOT_IW(SLOT_IW)) u_feed (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_enabled),
        .load      (load),
        .slot_idx  (slot_idx),
        .len       (len_s),
        .mono_ok   (mono & ~fmt[1]),
        .fill_prev (fill_prev),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ur_clr    (ur_clr),
        .word      (word),
        .tx_ready  (tx_ready),
        .ur_any    (ur_any),
        .ur_slot   (ur_slot)
    );

    aud_tx_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .en    (tx_enabled),
        .tick  (bclk_en),
        .load  (load),
        .word  (word),
        .delay (~fmt[0]),
        .sdo   (sdo)
    );
endmodule

// File: rtl/aud_ser_tx_chk.sv
`timescale 1ns/1ps
module aud_ser_tx_chk #(
    parameter int SLOTS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bclk_en,
    input logic             en_set,
    input logic             en_clr,
    input logic             wr_en,
    input logic             ur_clr,
    input logic             sdo,
    input logic             tx_ready,
    input logic             tx_enabled,
    input logic             ur_any,
    input logic [SLOTS-1:0] ur_slot
);
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_ready);  // R1

    AST_BOTH_STROBES_OFF: assert property (@(posedge clk) disable iff (rst)
        en_set && en_clr |=> !tx_enabled);  // R2

    AST_SET_TURNS_ON: assert property (@(posedge clk) disable iff (rst)
        en_set && !en_clr |=> tx_enabled);  // R2

    AST_OFF_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tx_enabled && $past(!tx_enabled) |-> !sdo);  // R3

    AST_OFF_NO_CONSUME: assert property (@(posedge clk) disable iff (rst)
        !tx_enabled && !tx_ready |=> !tx_ready);  // R3

    AST_SDO_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        tx_enabled && $past(tx_enabled) && $past(!bclk_en) |-> $stable(sdo));  // R9

    AST_UR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ur_any && !ur_clr |=> ur_any);  // R13

    AST_UR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ur_clr |=> !ur_any && (ur_slot == '0));  // R13

    AST_UR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (ur_slot != '0) == ur_any);  // R13
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/aud_ser_tx_test.sv
`timescale 1ns/1ps
module aud_ser_tx_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0, frame_start = 1'b0;
    logic        en_set = 1'b0, en_clr = 1'b0, wr_en = 1'b0, ur_clr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  fmt = '0;
    logic [2:0]  len_code = '0;
    logic        slot24 = 1'b0, mono = 1'b0, fill_prev = 1'b0;
    logic [2:0]  tdm_last = '0;
    logic        sdo, ws, tx_ready, tx_enabled, ur_any;
    logic [7:0]  ur_slot;

    int checks = 0;
    int failures = 0;

    logic        cap_sdo [0:255];
    logic        cap_ws  [0:255];
    logic [31:0] q [0:7];
    int          q_n = 0, q_i = 0;
    logic [31:0] exp_smp [0:7];
    int          ew = 16, el = 16, ed = 0;

    aud_ser_tx uut (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .frame_start(frame_start),
        .en_set(en_set), .en_clr(en_clr), .wr_en(wr_en), .wr_data(wr_data),
        .fmt(fmt), .len_code(len_code), .slot24(slot24), .mono(mono),
        .fill_prev(fill_prev), .tdm_last(tdm_last), .ur_clr(ur_clr),
        .sdo(sdo), .ws(ws), .tx_ready(tx_ready), .tx_enabled(tx_enabled),
        .ur_any(ur_any), .ur_slot(ur_slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic start(input logic [1:0] f, input logic [2:0] l, input logic s24,
                         input logic m, input logic fp, input logic [2:0] tl);
        @(negedge clk);
        fmt = f; len_code = l; slot24 = s24; mono = m; fill_prev = fp; tdm_last = tl;
        rst = 1'b1; q_n = 0; q_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_en(input logic s, input logic c);
        @(negedge clk); en_set = s; en_clr = c;
        @(negedge clk); en_set = 1'b0; en_clr = 1'b0;
    endtask

    task automatic run_ticks(input int n, input int fs2);
        for (int t = 0; t < n; t++) begin
            @(negedge clk); bclk_en = 1'b1; frame_start = (t == 0) || (t == fs2);
            @(negedge clk); bclk_en = 1'b0; frame_start = 1'b0;
            cap_sdo[t] = sdo; cap_ws[t] = ws;
            if (tx_ready && q_i < q_n) begin
                wr_en = 1'b1; wr_data = q[q_i]; q_i++;
            end
            @(negedge clk); wr_en = 1'b0;
            @(negedge clk);
        end
    endtask

    function automatic logic exp_bit(input int t);
        int tt, s, p;
        tt = t - ed;
        if (tt < 0) return 1'b0;
        s = tt / ew; p = tt % ew;
        if (p >= el) return 1'b0;
        return exp_smp[s][el-1-p];
    endfunction

    task automatic cmp_stream(input string req, input int base, input int cnt);
        int bad = -1;
        for (int k = 0; k < cnt; k++)
            if (bad < 0 && cap_sdo[base+k] !== exp_bit(k)) bad = k;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, $sformatf("%s sdo bit %0d", req, bad), 32'(cap_sdo[base+bad]), 32'(exp_bit(bad)));
    endtask

    task automatic cmp_ws(input string req, input int cnt, input int nslot, input logic tdm);
        int bad = -1;
        logic e;
        for (int t = 0; t < cnt; t++) begin
            e = tdm ? ((t % (ew*nslot)) == 0) : (((t / ew) % 2) == 1);
            if (bad < 0 && cap_ws[t] !== e) bad = t;
        end
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, $sformatf("%s ws tick %0d", req, bad), 32'(cap_ws[bad]), 32'(~cap_ws[bad]));
    endtask

    // R1: reset values and holding-register handshake
    task automatic t_reset_ready();
        start(2'd1, 3'd4, 0, 0, 0, 0);
        chk(tx_ready === 1'b1, "R1 ready after reset", 32'(tx_ready), 1);
        chk(tx_enabled === 1'b0, "R1 disabled after reset", 32'(tx_enabled), 0);
        chk(sdo === 1'b0 && ws === 1'b0, "R1 line idle after reset", {sdo, ws}, 0);
        chk(ur_any === 1'b0 && ur_slot === 8'h00, "R1 flags clear after reset", 32'(ur_slot), 0);
        write_word(32'h1234);
        chk(tx_ready === 1'b0, "R1 write fills holding", 32'(tx_ready), 0);
        pulse_en(1, 0);
        run_ticks(1, -1);
        chk(tx_ready === 1'b1, "R1 slot start consumes word", 32'(tx_ready), 1);
    endtask

    // R2 R3: strobes and the disabled state
    task automatic t_enable();
        start(2'd1, 3'd4, 0, 0, 0, 0);
        pulse_en(1, 1);
        chk(tx_enabled === 1'b0, "R2 both strobes disable", 32'(tx_enabled), 0);
        pulse_en(1, 0);
        chk(tx_enabled === 1'b1, "R2 set strobe enables", 32'(tx_enabled), 1);
        pulse_en(0, 1);
        chk(tx_enabled === 1'b0, "R2 clear strobe disables", 32'(tx_enabled), 0);
        write_word(32'hFFFF);
        run_ticks(40, -1);
        begin
            int ones = 0;
            for (int t = 0; t < 40; t++) if (cap_sdo[t] !== 1'b0) ones++;
            chk(ones == 0, "R3 line silent while disabled", ones, 0);
        end
        chk(tx_ready === 1'b0, "R3 no consumption while disabled", 32'(tx_ready), 0);
        chk(ur_any === 1'b0, "R3 no underrun while disabled", 32'(ur_any), 0);
    endtask

    // R6 R7 R4: I2S, 16-bit, delayed MSB
    task automatic t_i2s16();
        start(2'd0, 3'd4, 0, 0, 0, 0);
        write_word(32'hA5C3);
        q[0] = 32'h1234; q[1] = 32'h8001; q[2] = 32'h7FFE; q_n = 3;
        pulse_en(1, 0);
        run_ticks(65, -1);
        exp_smp[0] = 32'hA5C3; exp_smp[1] = 32'h1234; exp_smp[2] = 32'h8001; exp_smp[3] = 32'h7FFE;
        ew = 16; el = 16; ed = 1;
        cmp_stream("R6 I2S 16-bit stream", 0, 65);
        cmp_ws("R7 stereo word select", 64, 2, 1'b0);
    endtask

    // R4 R14 R9: left-justified 24-bit in 24-bit slots, upper word bits ignored
    task automatic t_lj24();
        start(2'd1, 3'd1, 1, 0, 0, 0);
        write_word(32'hFFAB_CDEF);
        q[0] = 32'h5512_3456; q_n = 1;
        pulse_en(1, 0);
        chk(sdo === 1'b0, "R9 no data before first bit clock", 32'(sdo), 0);
        run_ticks(48, -1);
        exp_smp[0] = 32'hAB_CDEF; exp_smp[1] = 32'h12_3456;
        ew = 24; el = 24; ed = 0;
        cmp_stream("R14 LJ 24-bit 24-slot stream", 0, 48);
        cmp_ws("R4 24-bit slot width", 48, 2, 1'b0);
    endtask

    // R4 R6: 32-bit I2S, LSB spills into next slot's first bit
    task automatic t_i2s32();
        start(2'd0, 3'd0, 1, 0, 0, 0);
        write_word(32'h8000_0001);
        q[0] = 32'hDEAD_BEEF; q[1] = 32'h0000_0003; q_n = 2;
        pulse_en(1, 0);
        run_ticks(97, -1);
        exp_smp[0] = 32'h8000_0001; exp_smp[1] = 32'hDEAD_BEEF; exp_smp[2] = 32'h3;
        ew = 32; el = 32; ed = 1;
        cmp_stream("R4 I2S 32-bit stream", 0, 97);
    endtask

    // R5 R14: 18-bit in 32-bit slots, zero padding
    task automatic t_lj18();
        start(2'd1, 3'd3, 0, 0, 0, 0);
        write_word(32'h0003_FFFF);
        q[0] = 32'hFFF2_AAAA; q_n = 1;
        pulse_en(1, 0);
        run_ticks(64, -1);
        exp_smp[0] = 32'h3FFFF; exp_smp[1] = 32'h2AAAA;
        ew = 32; el = 18; ed = 0;
        cmp_stream("R5 18-bit padded stream", 0, 64);
    endtask

    // R7 R6: TDM framing, both delay variants
    task automatic t_tdm();
        start(2'd3, 3'd6, 0, 0, 0, 3'd3);
        write_word(32'h81);
        q[0] = 32'h42; q[1] = 32'h24; q[2] = 32'h18; q_n = 3;
        pulse_en(1, 0);
        run_ticks(32, -1);
        exp_smp[0] = 32'h81; exp_smp[1] = 32'h42; exp_smp[2] = 32'h24; exp_smp[3] = 32'h18;
        ew = 8; el = 8; ed = 0;
        cmp_stream("R7 TDM-LJ 4x8 stream", 0, 32);
        cmp_ws("R7 TDM frame pulse", 32, 4, 1'b1);

        start(2'd2, 3'd4, 0, 0, 0, 3'd2);
        write_word(32'hF00D);
        q[0] = 32'h0BAD; q[1] = 32'hC0DE; q_n = 2;
        pulse_en(1, 0);
        run_ticks(49, -1);
        exp_smp[0] = 32'hF00D; exp_smp[1] = 32'h0BAD; exp_smp[2] = 32'hC0DE;
        ew = 16; el = 16; ed = 1;
        cmp_stream("R6 TDM delayed 3x16 stream", 0, 49);
        cmp_ws("R7 TDM three-slot frame", 48, 3, 1'b1);
    endtask

    // R11: packed 16 and packed 8
    task automatic t_packed();
        start(2'd1, 3'd5, 0, 0, 0, 0);
        write_word(32'hBBBB_AAAA);
        q[0] = 32'hDDDD_CCCC; q_n = 1;
        pulse_en(1, 0);
        run_ticks(64, -1);
        exp_smp[0] = 32'hAAAA; exp_smp[1] = 32'hBBBB; exp_smp[2] = 32'hCCCC; exp_smp[3] = 32'hDDDD;
        ew = 16; el = 16; ed = 0;
        cmp_stream("R11 packed 16 halves order", 0, 64);

        start(2'd1, 3'd7, 0, 0, 0, 0);
        write_word(32'hFFFF_2211);
        q[0] = 32'h0000_4433; q_n = 1;
        pulse_en(1, 0);
        run_ticks(32, -1);
        exp_smp[0] = 32'h11; exp_smp[1] = 32'h22; exp_smp[2] = 32'h33; exp_smp[3] = 32'h44;
        ew = 8; el = 8; ed = 0;
        cmp_stream("R11 packed 8 halves order", 0, 32);
        chk(ur_any === 1'b0, "R11 odd slot needs no word", 32'(ur_any), 0);
    endtask

    // R10: mono duplication
    task automatic t_mono();
        start(2'd1, 3'd4, 0, 1, 0, 0);
        write_word(32'h1111);
        q[0] = 32'h2222; q_n = 1;
        pulse_en(1, 0);
        run_ticks(64, -1);
        exp_smp[0] = 32'h1111; exp_smp[1] = 32'h1111; exp_smp[2] = 32'h2222; exp_smp[3] = 32'h2222;
        ew = 16; el = 16; ed = 0;
        cmp_stream("R10 mono right repeats left", 0, 64);
        chk(ur_any === 1'b0, "R10 right slot consumes nothing", 32'(ur_any), 0);
    endtask

    // R12 R13: underrun fill and flags
    task automatic t_underrun();
        start(2'd1, 3'd4, 0, 0, 0, 0);
        write_word(32'hF00F);
        pulse_en(1, 0);
        run_ticks(32, -1);
        exp_smp[0] = 32'hF00F; exp_smp[1] = 32'h0;
        ew = 16; el = 16; ed = 0;
        cmp_stream("R12 zero fill", 0, 32);
        chk(ur_any === 1'b1, "R13 summary set", 32'(ur_any), 1);
        chk(ur_slot === 8'h02, "R13 starved slot flagged", 32'(ur_slot), 32'h02);
        @(negedge clk); ur_clr = 1'b1;
        @(negedge clk); ur_clr = 1'b0;
        chk(ur_any === 1'b0 && ur_slot === 8'h00, "R13 clear strobe", 32'(ur_slot), 0);

        start(2'd1, 3'd4, 0, 0, 1, 0);
        write_word(32'h9009);
        pulse_en(1, 0);
        run_ticks(32, -1);
        exp_smp[0] = 32'h9009; exp_smp[1] = 32'h9009;
        cmp_stream("R12 previous-sample fill", 0, 32);

        start(2'd3, 3'd6, 0, 0, 0, 3'd3);
        write_word(32'h11);
        q[0] = 32'h22; q_n = 1;
        pulse_en(1, 0);
        run_ticks(32, -1);
        exp_smp[0] = 32'h11; exp_smp[1] = 32'h22; exp_smp[2] = 32'h0; exp_smp[3] = 32'h0;
        ew = 8; el = 8; ed = 0;
        cmp_stream("R12 TDM zero fill", 0, 32);
        chk(ur_slot === 8'h0C, "R13 TDM per-slot flags", 32'(ur_slot), 32'h0C);
    endtask

    // R8: frame restart mid-slot
    task automatic t_restart();
        start(2'd1, 3'd4, 0, 0, 0, 0);
        write_word(32'hC35A);
        q[0] = 32'h5AC3; q[1] = 32'h0FF0; q_n = 2;
        pulse_en(1, 0);
        run_ticks(37, 5);
        ew = 16; el = 16; ed = 0;
        exp_smp[0] = 32'hC35A;
        cmp_stream("R8 bits before restart", 0, 5);
        exp_smp[0] = 32'h5AC3; exp_smp[1] = 32'h0FF0;
        cmp_stream("R8 frame after restart", 5, 32);
        chk(cap_ws[5] === 1'b0 && cap_ws[21] === 1'b1, "R8 word select realigned",
            {cap_ws[5], cap_ws[21]}, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_ready();
        t_enable();
        t_i2s16();
        t_lj24();
        t_i2s32();
        t_lj18();
        t_tdm();
        t_packed();
        t_mono();
        t_underrun();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule